// File: doc/BRIEF.md
# Flash Embedded-Operation Status Responder

This block reproduces, in synthesizable logic, what a parallel flash device shows on its data bus while its internal program or erase algorithm runs. It holds a small byte store and accepts single-byte program requests and whole-store erase requests. Each accepted request starts an internal busy timer. While that timer runs, a read returns a status byte instead of stored data. Once the operation has finished, reads return stored data again.

A host polls by reading repeatedly. The toggle bit flips on every read access while an operation is active or has failed. It does not flip on plain clock cycles. When two reads in a row return the same value, the operation is over. The error bit flags two cases: an operation that ran past the timeout budget, and a program request that tried to raise a stored 0 bit to 1. After an error the block stays in status mode until the host pulses a recovery input.

Top module: `flash_op_status`

## Requirements
- R1: After reset, `rdata` is 8'h00 and every byte of the store holds 8'hFF.
- R2: In array mode, a read pulse on `rd` loads the byte at `addr` into `rdata`, visible after that clock edge, and `rdata` then holds until the next read.
- R3: A program writes (old AND new) to the addressed byte PROG_CYC cycles after acceptance, so it can only clear bits. An erase sets every byte to 8'hFF after ERASE_CYC cycles.
- R4: While an operation is busy or failed, a read returns a status byte whose bit 6 inverts on every read access and stays unchanged on cycles without a read. Bits 4 down to 0 of the status byte are 0.
- R5: After an operation completes without error, two consecutive reads of the same address return identical array data.
- R6: During a program, status bit 7 is the complement of bit 7 of the data being programmed. During an erase, status bit 7 is 0.
- R7: A program whose data has a 1 where the stored byte has a 0 ends in the failed state, with status bit 5 set. The store still receives (old AND new).
- R8: An operation still busy after TMO_CYC cycles enters the failed state with status bit 5 set, and the store is left unchanged.
- R9: The failed state persists, with bit 6 still toggling on reads, until a pulse on `op_reset`. That pulse returns the block to array mode.
- R10: Program or erase requests that arrive while an operation is busy or failed are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_reset | input | 1 | Leaves the failed state and returns to array mode |
| rd | input | 1 | Read access strobe, one pulse per read |
| prog | input | 1 | Program request for byte `addr` with `wdata` |
| erase | input | 1 | Erase request for the whole store (wins over `prog`) |
| addr | input | ADDR_W | Byte address for reads and programs |
| wdata | input | 8 | Data to program |
| rdata | output | 8 | Array data or status byte from the last read |

## Verification
On every cycle, the assertions check four things: the toggle bit changes on each active read and holds otherwise, the failed state stays sticky until the recovery pulse, status bytes carry zero low bits and a set error bit while failed, and a byte program never raises a bit. Other behaviour can only be shown by the bench's scenarios. These include the toggle sequence a poller sees, the value of bit 7 for program versus erase, the AND result left by a conflicting program, and an erase that times out when a second instance is given a short budget. The same holds for requests being ignored while busy and for data reads matching once the operation ends.

// File: rtl/fos_pkg.sv
package fos_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_FAIL} fos_state_e;
  typedef enum logic {OP_PROG, OP_ERASE} fos_op_e;

  // programming can only pull bits low
  function automatic logic [BYTE_W-1:0] prog_merge(input logic [BYTE_W-1:0] old_b,
                                                   input logic [BYTE_W-1:0] new_b);
    return old_b & new_b;
  endfunction

  // a requested 1 over a stored 0 cannot be produced
  function automatic logic lifts_zero(input logic [BYTE_W-1:0] old_b,
                                      input logic [BYTE_W-1:0] new_b);
    return |(~old_b & new_b);
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic dq7, input logic tog,
                                                    input logic err);
    return {dq7, tog, err, 5'b0};
  endfunction
endpackage

// File: rtl/fos_seq.sv
module fos_seq import fos_pkg::*; #(
  parameter int ADDR_W    = 4,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 24,
  parameter int TMO_CYC   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_reset,
  input  logic              prog,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] old_byte,
  output fos_state_e        state,
  output fos_op_e           lat_op,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [BYTE_W-1:0] lat_data,
  output logic              ev_wr_byte,
  output logic              ev_wipe
);
  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ?
                         ((PROG_CYC > TMO_CYC) ? PROG_CYC : TMO_CYC) :
                         ((ERASE_CYC > TMO_CYC) ? ERASE_CYC : TMO_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;
  logic             lat_conf;
  logic             accept;
  logic             ev_end;
  logic             ev_timeout;
  logic [CNT_W-1:0] target;

  assign accept     = (state == ST_IDLE) && (prog || erase);
  assign target     = (lat_op == OP_ERASE) ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);
  assign ev_end     = (state == ST_BUSY) && (cnt == target);
  assign ev_timeout = (state == ST_BUSY) && (cnt == CNT_W'(TMO_CYC - 1)) && !ev_end;
  assign ev_wr_byte = ev_end && (lat_op == OP_PROG);
  assign ev_wipe    = ev_end && (lat_op == OP_ERASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lat_op   <= OP_PROG;
      lat_addr <= '0;
      lat_data <= '0;
      lat_conf <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_BUSY;
          cnt      <= '0;
          lat_op   <= erase ? OP_ERASE : OP_PROG;
          lat_addr <= addr;
          lat_data <= erase ? '1 : wdata;
          lat_conf <= !erase && lifts_zero(old_byte, wdata);
        end
        ST_BUSY: begin
          if (ev_timeout)  state <= ST_FAIL;
          else if (ev_end) state <= lat_conf ? ST_FAIL : ST_IDLE;
          else             cnt   <= cnt + 1'b1;
        end
        ST_FAIL: if (op_reset) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_fail_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAIL && !op_reset) |=> (state == ST_FAIL));

  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && (prog || erase)) |=> ($stable(lat_addr) && $stable(lat_data)));

  p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY) |-> (cnt < CNT_W'(TMO_CYC)));
endmodule

// File: rtl/fos_store.sv
module fos_store import fos_pkg::*; #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_byte,
  input  logic              wipe,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [BYTE_W-1:0] rbyte
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][BYTE_W-1:0] mem_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      mem_q[i] <= '1;
      else if (wipe)                                   mem_q[i] <= '1;
      else if (wr_byte && waddr == ADDR_W'(i))         mem_q[i] <= prog_merge(mem_q[i], wdata);
    end
  end

  assign rbyte = mem_q[raddr];

  p_prog_no_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte |=> ((mem_q[$past(waddr)] | $past(mem_q[waddr])) == $past(mem_q[waddr])));

  p_wipe_all_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (mem_q[0] == '1 && mem_q[DEPTH-1] == '1));
endmodule

// File: rtl/fos_status.sv
module fos_status import fos_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              active,
  input  logic              failed,
  input  fos_op_e           op,
  input  logic [BYTE_W-1:0] target_data,
  output logic [BYTE_W-1:0] status
);
  logic tog;
  logic dq7;
  logic rd_active;

  assign rd_active = rd && active;
  assign dq7       = (op == OP_PROG) ? ~target_data[BYTE_W-1] : 1'b0;
  assign status    = status_byte(dq7, tog, failed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tog <= 1'b0;
    else if (rd_active) tog <= ~tog;
  end

  p_tog_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |=> (tog != $past(tog)));

  p_tog_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_active |=> $stable(tog));
endmodule

// File: rtl/flash_op_status.sv
module flash_op_status import fos_pkg::*; #(
  parameter int ADDR_W    = 4,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 24,
  parameter int TMO_CYC   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_reset,
  input  logic              rd,
  input  logic              prog,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  fos_state_e        state;
  fos_op_e           lat_op;
  logic [ADDR_W-1:0] lat_addr;
  logic [BYTE_W-1:0] lat_data;
  logic              ev_wr_byte;
  logic              ev_wipe;
  logic [BYTE_W-1:0] arr_byte;
  logic [BYTE_W-1:0] stat_byte;
  logic              active;
  logic              failed;

  assign active = (state != ST_IDLE);
  assign failed = (state == ST_FAIL);

  fos_seq #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .TMO_CYC(TMO_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .op_reset(op_reset), .prog(prog), .erase(erase),
    .addr(addr), .wdata(wdata), .old_byte(arr_byte), .state(state), .lat_op(lat_op),
    .lat_addr(lat_addr), .lat_data(lat_data), .ev_wr_byte(ev_wr_byte), .ev_wipe(ev_wipe)
  );

  fos_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_byte(ev_wr_byte), .wipe(ev_wipe),
    .waddr(lat_addr), .wdata(lat_data), .raddr(addr), .rbyte(arr_byte)
  );

  fos_status u_status (
    .clk(clk), .rst_n(rst_n), .rd(rd), .active(active), .failed(failed),
    .op(lat_op), .target_data(lat_data), .status(stat_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= active ? stat_byte : arr_byte;
  end

  p_err_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && failed) |=> rdata[5]);

  p_status_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && active) |=> (rdata[4:0] == 5'b0));

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

// File: tb/tb_flash_op_status.sv
module tb_flash_op_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_reset = 1'b0;
  logic       rd = 1'b0;
  logic       prog = 1'b0;
  logic       erase = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] rdata_to;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit tog_m = 1'b0;
  bit pend = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  flash_op_status dut (.clk(clk), .rst_n(rst_n), .op_reset(op_reset), .rd(rd), .prog(prog),
    .erase(erase), .addr(addr), .wdata(wdata), .rdata(rdata));

  flash_op_status #(.TMO_CYC(16)) dut_to (.clk(clk), .rst_n(rst_n), .op_reset(op_reset), .rd(rd),
    .prog(prog), .erase(erase), .addr(addr), .wdata(wdata), .rdata(rdata_to));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare each read result against the scoreboard
  always @(posedge clk) pend <= rd;
  always @(negedge clk) begin
    if (pend) begin
      if (sb_q.size() == 0) check("SB-empty", rdata, 8'hxx);
      else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic do_read(input logic [3:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic rd_status(input logic [3:0] a, input logic dq7, input logic err, input string tag);
    do_read(a, {dq7, tog_m, err, 5'b0}, tag);
    tog_m = ~tog_m;
  endtask

  task automatic cmd(input bit is_erase, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    prog = !is_erase; erase = is_erase; addr = a; wdata = d;
    @(negedge clk);
    prog = 1'b0; erase = 1'b0;
  endtask

  task automatic pulse_reset_op();
    @(negedge clk); op_reset = 1'b1;
    @(negedge clk); op_reset = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata after reset", rdata, 8'h00);
    rst_n = 1'b1;
    do_read(4'd0, 8'hFF, "R1 erased store");
    do_read(4'd9, 8'hFF, "R2 idle read");

    // program 0xA5 into erased byte 3: bit7=1 so dq7 reads 0
    cmd(1'b0, 4'd3, 8'hA5);
    rd_status(4'd3, 1'b0, 1'b0, "R4 R6 busy read 1");
    rd_status(4'd3, 1'b0, 1'b0, "R4 busy read 2");
    rd_status(4'd3, 1'b0, 1'b0, "R4 busy read 3");
    repeat (10) @(negedge clk);
    do_read(4'd3, 8'hA5, "R3 R5 data after program");
    do_read(4'd3, 8'hA5, "R5 second read equal");

    // conflicting program: 0x0F over 0xA5 lifts zeros; bit7=0 so dq7 reads 1
    cmd(1'b0, 4'd3, 8'h0F);
    rd_status(4'd3, 1'b1, 1'b0, "R6 R7 conflict busy 1");
    rd_status(4'd3, 1'b1, 1'b0, "R4 conflict busy 2");
    rd_status(4'd3, 1'b1, 1'b0, "R4 conflict busy 3");
    repeat (20) @(negedge clk);
    rd_status(4'd3, 1'b1, 1'b1, "R7 error flag");
    cmd(1'b0, 4'd4, 8'h00);
    repeat (5) @(negedge clk);
    rd_status(4'd4, 1'b1, 1'b1, "R9 R10 still failed");
    pulse_reset_op();
    do_read(4'd3, 8'h05, "R7 R9 AND stored, array mode");
    do_read(4'd4, 8'hFF, "R10 request during fail ignored");

    // clean program, then a subset program
    cmd(1'b0, 4'd5, 8'h3C);
    rd_status(4'd5, 1'b1, 1'b0, "R6 dq7 complement");
    repeat (12) @(negedge clk);
    do_read(4'd5, 8'h3C, "R3 program result");
    cmd(1'b0, 4'd5, 8'h34);
    repeat (12) @(negedge clk);
    do_read(4'd5, 8'h34, "R3 subset program no error");

    // erase: dut completes, dut_to times out at 16 cycles
    cmd(1'b1, 4'd0, 8'h00);
    rd_status(4'd0, 1'b0, 1'b0, "R6 erase dq7 zero");
    cmd(1'b0, 4'd7, 8'h00);
    repeat (40) @(negedge clk);
    do_read(4'd7, 8'hFF, "R10 R3 ignored program, erased");
    check("R8 timeout status bits", rdata_to & 8'hA0, 8'h20);
    check("R4 timeout low bits", rdata_to & 8'h1F, 8'h00);
    do_read(4'd3, 8'hFF, "R3 erase clears byte 3");
    pulse_reset_op();
    do_read(4'd3, 8'hFF, "R9 reset with no fail has no effect");
    check("R8 store unchanged after timeout", rdata_to, 8'h05);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule